// File: doc/BRIEF.md
# Low-Power Register Write Synchronizer

This block moves register writes issued on a fast bus clock into a slow low-power clock domain (nominally 32 kHz) and tells software how each write is progressing. A bus write to any ordinary register address is captured into a holding register. It is announced to the slow domain with a toggle request and committed there as a single-cycle pulse carrying the address and data. A toggle acknowledge then returns to the bus domain to close the transfer. Only one write can be in flight at a time.

Progress is reported through four status flags: busy, ready-for-next, write-done and write-error. Each of the last three has an interrupt enable, and the enables drive a single interrupt line. The interrupt-enable register lives in the bus domain. Writes to it take effect in the next bus cycle and never pass through the crossing. The status register itself is reached through the crossing, so clearing the error flag takes a full round trip.

Top module: `lp_write_sync`

## Requirements
- R1: After reset the status register reads busy 0, ready-for-next 1, write-done 0 and write-error 0. The interrupt-enable register reads 0, `irq` is low, and a read of any address other than status or interrupt-enable returns 0.
- R2: A write to an address other than status (word 5) or interrupt-enable (word 6), issued while not busy, raises busy and drops ready-for-next in the next bus cycle. Its address and data then appear on the low-power commit port in exactly one pulse.
- R3: Busy stays high until the acknowledge returns from the low-power domain. In that cycle busy clears, ready-for-next sets and write-done sets.
- R4: Any status read returns the flags as they stood before the read and clears write-done. A second status read therefore shows write-done at 0.
- R5: A write to interrupt-enable updates it in the next bus cycle, whether or not a transfer is in flight. It never sets write-done, never changes busy, raises no error and is never forwarded to the commit port.
- R6: A write arriving while busy is high is discarded: it never reaches the commit port, and the transfer already in flight completes with its own data. Write-error is set by it.
- R7: Writing the status register goes through the crossing and sets write-done when it finishes, but it is never presented on the commit port. If data bit 7 is 1, write-error clears only when that transfer completes and stays set while it is in flight. If bit 7 is 0, write-error is left as it is.
- R8: Status layout: bit 10 is busy, bit 9 is ready-for-next, bit 8 is write-done and bit 7 is write-error. Interrupt-enable bits 9, 8 and 7 enable ready-for-next, write-done and write-error. `irq` is the OR of each enabled flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| lp_clk | input | 1 | Low-power domain clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe (wins over a read in the same cycle) |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt, OR of enabled status flags |
| lp_wr_valid | output | 1 | One low-power-cycle pulse per committed write |
| lp_wr_addr | output | ADDR_W | Address of the committed write |
| lp_wr_data | output | DATA_W | Data of the committed write |

## Verification
A lost or duplicated toggle in the handshake would show at the ports within a few low-power cycles. Either busy would never drop, or a second commit pulse would appear for one accepted write. A done flag that the wrong path sets or clears would show on the very next status read, because each read reports and then clears it. A collision that leaks into the holding register would show as wrong data on the commit port of the write in flight. An error clear that does not wait for the round trip would show as error already low in a status read taken straight after the clearing write.

// File: rtl/lpws_pkg.sv
package lpws_pkg;

  // status flag bit positions (software decodes these)
  localparam int unsigned ST_BUSY_BIT = 10;
  localparam int unsigned ST_NEXT_BIT = 9;
  localparam int unsigned ST_DONE_BIT = 8;
  localparam int unsigned ST_ERR_BIT  = 7;

  // interrupt-enable field: bits [IE_LSB +: IE_W] = {next, done, err}
  localparam int unsigned IE_LSB = 7;
  localparam int unsigned IE_W   = 3;

  typedef enum logic [1:0] {
    ACC_TARGET = 2'd0,
    ACC_STATUS = 2'd1,
    ACC_IE     = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/lpws_rst_sync.sv
module lpws_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[SW-2:0], 1'b1};
  end

  assign rst_n = chain_q[SW-1];
endmodule

// File: rtl/lpws_bit_sync.sv
module lpws_bit_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int unsigned SN = (STAGES < 2) ? 2 : STAGES;

  logic [WIDTH-1:0] stg_q [SN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SN; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < SN; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[SN-1];
endmodule

// File: rtl/lpws_bus_ctrl.sv
module lpws_bus_ctrl
  import lpws_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STATUS_ADDR = 5,
  parameter int unsigned IE_ADDR     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              req_tgl,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  input  logic              ack_sync
);

  // register state
  logic              busy_q, done_q, err_q, errclr_q, req_q, ack_seen_q;
  logic [IE_W-1:0]   ie_q;
  logic [ADDR_W-1:0] haddr_q;
  logic [DATA_W-1:0] hdata_q, rdata_q;

  // next state
  logic              busy_d, done_d, err_d, errclr_d, req_d;
  logic [IE_W-1:0]   ie_d;
  logic [ADDR_W-1:0] haddr_d;
  logic [DATA_W-1:0] hdata_d, rdata_d;
  logic              rd_en;

  acc_kind_e kind;
  logic      ack_edge, wr_sync, accept, collide, st_read;
  logic [IE_W-1:0] flag_vec;

  always_comb begin
    if (bus_addr == ADDR_W'(IE_ADDR))          kind = ACC_IE;
    else if (bus_addr == ADDR_W'(STATUS_ADDR)) kind = ACC_STATUS;
    else                                       kind = ACC_TARGET;
  end

  assign ack_edge = ack_sync ^ ack_seen_q;
  assign wr_sync  = bus_wr && (kind != ACC_IE);
  assign accept   = wr_sync && !busy_q;
  assign collide  = wr_sync && busy_q;
  assign st_read  = bus_rd && !bus_wr && (kind == ACC_STATUS);
  assign flag_vec = {~busy_q, done_q, err_q};

  always_comb begin
    busy_d   = busy_q;
    done_d   = done_q;
    err_d    = err_q;
    errclr_d = errclr_q;
    req_d    = req_q;
    ie_d     = ie_q;
    haddr_d  = haddr_q;
    hdata_d  = hdata_q;
    rdata_d  = rdata_q;
    rd_en    = bus_rd && !bus_wr;

    if (accept) begin
      busy_d   = 1'b1;
      req_d    = ~req_q;
      haddr_d  = bus_addr;
      hdata_d  = bus_wdata;
      errclr_d = (kind == ACC_STATUS) && bus_wdata[ST_ERR_BIT];
    end else if (ack_edge) begin
      busy_d   = 1'b0;
    end

    // completion beats a same-cycle status read
    if (ack_edge)     done_d = 1'b1;
    else if (st_read) done_d = 1'b0;

    // a collision beats a same-cycle error clear
    if (collide)                  err_d = 1'b1;
    else if (ack_edge && errclr_q) err_d = 1'b0;

    if (bus_wr && (kind == ACC_IE)) ie_d = bus_wdata[IE_LSB +: IE_W];

    if (rd_en) begin
      rdata_d = '0;
      if (kind == ACC_STATUS) begin
        rdata_d[ST_BUSY_BIT] = busy_q;
        rdata_d[ST_NEXT_BIT] = ~busy_q;
        rdata_d[ST_DONE_BIT] = done_q;
        rdata_d[ST_ERR_BIT]  = err_q;
      end else if (kind == ACC_IE) begin
        rdata_d[IE_LSB +: IE_W] = ie_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      errclr_q   <= 1'b0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      ie_q       <= '0;
      haddr_q    <= '0;
      hdata_q    <= '0;
      rdata_q    <= '0;
    end else begin
      busy_q     <= busy_d;
      done_q     <= done_d;
      err_q      <= err_d;
      req_q      <= req_d;
      ack_seen_q <= ack_sync;
      ie_q       <= ie_d;
      if (accept) begin
        errclr_q <= errclr_d;
        haddr_q  <= haddr_d;
        hdata_q  <= hdata_d;
      end
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = |(ie_q & flag_vec);
  assign req_tgl   = req_q;
  assign hold_addr = haddr_q;
  assign hold_data = hdata_q;

  // ---------------- assertions ----------------
  p_ack_only_when_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_edge |-> busy_q);
  p_busy_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_edge) |=> busy_q);
  p_ack_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_edge |=> (!busy_q && done_q));
  p_status_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_read && !ack_edge) |=> !done_q);
  p_ie_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && kind == ACC_IE && !ack_edge) |=> ($stable(done_q) && $stable(busy_q)));
  p_collide_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> err_q);
  p_collide_keeps_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> ($stable(hdata_q) && $stable(haddr_q) && $stable(req_q)));

endmodule

// File: rtl/lpws_lp_commit.sv
module lpws_lp_commit #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STATUS_ADDR = 5
) (
  input  logic              lp_clk,
  input  logic              lp_rst_n,
  input  logic              req_sync,
  input  logic [ADDR_W-1:0] hold_addr,
  input  logic [DATA_W-1:0] hold_data,
  output logic              ack_tgl,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);

  logic              seen_q, ack_q, valid_q;
  logic [ADDR_W-1:0] caddr_q;
  logic [DATA_W-1:0] cdata_q;

  logic              req_edge, fwd, ack_d, valid_d;

  always_comb begin
    req_edge = req_sync ^ seen_q;
    fwd      = req_edge && (hold_addr != ADDR_W'(STATUS_ADDR));
    ack_d    = ack_q ^ req_edge;
    valid_d  = fwd;
  end

  always_ff @(posedge lp_clk or negedge lp_rst_n) begin
    if (!lp_rst_n) begin
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      caddr_q <= '0;
      cdata_q <= '0;
    end else begin
      seen_q  <= req_sync;
      ack_q   <= ack_d;
      valid_q <= valid_d;
      if (fwd) begin
        caddr_q <= hold_addr;
        cdata_q <= hold_data;
      end
    end
  end

  assign ack_tgl      = ack_q;
  assign commit_valid = valid_q;
  assign commit_addr  = caddr_q;
  assign commit_data  = cdata_q;

  p_commit_single_pulse_r2: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
    commit_valid |=> !commit_valid);
  p_ack_follows_req_r3: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
    req_edge |=> (ack_q != $past(ack_q)));

endmodule

// File: rtl/lp_write_sync.sv
module lp_write_sync #(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned STATUS_ADDR = 5,
  parameter int unsigned IE_ADDR     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              lp_clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              lp_wr_valid,
  output logic [ADDR_W-1:0] lp_wr_addr,
  output logic [DATA_W-1:0] lp_wr_data
);

  logic              rst_n_bus, rst_n_lp;
  logic              req_tgl, req_sync, ack_tgl, ack_sync;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  lpws_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_bus (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n_bus));

  lpws_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_lp (
    .clk(lp_clk), .arst_n(arst_n), .rst_n(rst_n_lp));

  lpws_bus_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR), .IE_ADDR(IE_ADDR)
  ) u_bus (
    .clk(clk), .rst_n(rst_n_bus),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .req_tgl(req_tgl), .hold_addr(hold_addr), .hold_data(hold_data),
    .ack_sync(ack_sync));

  lpws_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(lp_clk), .rst_n(rst_n_lp), .d(req_tgl), .q(req_sync));

  lpws_bit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n_bus), .d(ack_tgl), .q(ack_sync));

  lpws_lp_commit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR)
  ) u_lp (
    .lp_clk(lp_clk), .lp_rst_n(rst_n_lp),
    .req_sync(req_sync), .hold_addr(hold_addr), .hold_data(hold_data),
    .ack_tgl(ack_tgl), .commit_valid(lp_wr_valid),
    .commit_addr(lp_wr_addr), .commit_data(lp_wr_data));

endmodule

// File: tb/lp_write_sync_tb.sv
`timescale 1ns/1ps
module lp_write_sync_tb;

  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_ST = 4'd5;
  localparam logic [AW-1:0] A_IE = 4'd6;
  localparam int NVEC = 4;
  localparam logic [AW+DW-1:0] VEC [NVEC] = '{
    {4'h0, 32'h1234_5678},
    {4'h3, 32'hDEAD_BEEF},
    {4'hF, 32'h0000_0001},
    {4'h7, 32'hFFFF_FFFF}
  };

  logic clk = 1'b0, lp_clk = 1'b0, arst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq, lp_wr_valid;
  logic [AW-1:0] lp_wr_addr;
  logic [DW-1:0] lp_wr_data;

  int n_cmp = 0, n_bad = 0, commits = 0;
  logic [AW-1:0] last_addr = '0;
  logic [DW-1:0] last_data = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always #42.5 lp_clk = ~lp_clk;

  lp_write_sync u_dut (
    .clk(clk), .lp_clk(lp_clk), .arst_n(arst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .lp_wr_valid(lp_wr_valid), .lp_wr_addr(lp_wr_addr), .lp_wr_data(lp_wr_data));

  always @(negedge lp_clk) begin
    if (lp_wr_valid) begin
      commits   = commits + 1;
      last_addr = lp_wr_addr;
      last_data = lp_wr_data;
    end
  end

  function automatic logic [DW-1:0] st(input bit b, input bit n, input bit d, input bit e);
    logic [DW-1:0] v = '0;
    v[10] = b; v[9] = n; v[8] = d; v[7] = e;
    return v;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (150) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    int c0;
    repeat (10) @(negedge clk);
    arst_n = 1'b1;
    repeat (100) @(negedge clk);

    // R1: reset state
    bus_read(A_ST, rd);      check("R1 status", rd, st(0,1,0,0));
    bus_read(A_IE, rd);      check("R1 ie", rd, '0);
    bus_read(4'h0, rd);      check("R1 other addr", rd, '0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // vector table: R2, R3, R4
    for (int i = 0; i < NVEC; i++) begin
      c0 = commits;
      bus_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
      bus_read(A_ST, rd);    check("R2 busy after accept", rd, st(1,0,0,0));
      settle();
      check("R2 one commit", commits, c0 + 1);
      check("R2 commit addr", {28'd0, last_addr}, {28'd0, VEC[i][AW+DW-1:DW]});
      check("R2 commit data", last_data, VEC[i][DW-1:0]);
      bus_read(A_ST, rd);    check("R3 done after ack", rd, st(0,1,1,0));
      bus_read(A_ST, rd);    check("R4 read clears done", rd, st(0,1,0,0));
    end

    // R5: interrupt-enable write while idle
    c0 = commits;
    bus_write(A_IE, 32'h0000_0300);
    bus_read(A_IE, rd);      check("R5 ie value", rd, 32'h0000_0300);
    bus_read(A_ST, rd);      check("R5 no done from ie write", rd, st(0,1,0,0));
    check("R5 ie not forwarded", commits, c0);
    // R5: interrupt-enable write while busy
    bus_write(4'h2, 32'h0000_00C3);
    bus_write(A_IE, 32'h0);
    bus_read(A_ST, rd);      check("R5 ie write while busy no error", rd, st(1,0,0,0));
    settle();
    check("R5 only target committed", commits, c0 + 1);
    bus_read(A_ST, rd);      check("R5 status after", rd, st(0,1,1,0));

    // R8: interrupt line
    bus_write(A_IE, 32'h0000_0200);
    check("R8 irq on next", {31'd0, irq}, 32'd1);
    bus_write(A_IE, 32'h0000_0100);
    check("R8 irq done idle", {31'd0, irq}, 32'd0);
    bus_write(4'h1, 32'h0000_0055);
    settle();
    check("R8 irq on done", {31'd0, irq}, 32'd1);
    bus_read(A_ST, rd);
    check("R8 irq after read", {31'd0, irq}, 32'd0);
    bus_write(A_IE, 32'h0);

    // R6: collision
    c0 = commits;
    bus_write(4'h1, 32'h0000_AAAA);
    bus_write(4'h2, 32'h0000_BBBB);
    bus_read(A_ST, rd);      check("R6 error set", rd, st(1,0,0,1));
    settle();
    check("R6 dropped write", commits, c0 + 1);
    check("R6 first data kept", last_data, 32'h0000_AAAA);
    bus_read(A_ST, rd);      check("R6 status after", rd, st(0,1,1,1));
    bus_write(A_IE, 32'h0000_0080);
    check("R8 irq on error", {31'd0, irq}, 32'd1);

    // R7: status writes
    c0 = commits;
    bus_write(A_ST, 32'h0);
    settle();
    check("R7 status write not forwarded", commits, c0);
    bus_read(A_ST, rd);      check("R7 error kept by 0", rd, st(0,1,1,1));
    bus_write(A_ST, 32'h0000_0080);
    bus_read(A_ST, rd);      check("R7 error held in flight", rd, st(1,0,0,1));
    settle();
    bus_read(A_ST, rd);      check("R7 error cleared", rd, st(0,1,1,0));
    check("R7 no commit", commits, c0);
    check("R8 irq gone", {31'd0, irq}, 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule